// File: doc/BRIEF.md
# SPI-4 Transmit Word Framer with Link Training

This block forms the 16-bit word stream for the transmit side of a source-synchronous packet link that follows the SPI-4 style. It draws entries from a show-ahead transmit FIFO. Each entry is either a payload data word or a control request. Data words leave unchanged with the control flag low. A control request supplies the upper twelve bits of a control word. The block fills the lowest four bits with a DIP-4 code. That code covers every data word sent since the previous control word, and the control word itself.

When the FIFO has nothing to offer, the block emits idle control words, each carrying its own DIP-4 code. It also emits training patterns. These run without a break while the far end reports the link as disabled. They are also inserted on a programmable beat interval, and each insertion repeats the pattern a programmable number of times. Training is never placed inside an open burst. The output is one registered word plus a control flag per clock. Serialization and the I/O drivers sit outside this block.

Top module: `spi4_tx_framer`

## Requirements
- R1: While `rst_n` is low, `tx_data` is 16'h0000 and `tx_ctl` is 1.
- R2: When no training runs and `fifo_valid` is high with `fifo_is_ctl` low, the block pops the entry (`fifo_rd` high). The next output beat is `fifo_word` unchanged, with `tx_ctl` 0. Entries leave in FIFO order, one per beat.
- R3: A popped control request (`fifo_is_ctl` high) is sent with `tx_ctl` 1. Its bits [15:4] are copied from `fifo_word[15:4]`, and bits [3:0] are replaced by the DIP-4 code. Bit 15 of a control word set to 1 marks a payload control word, which opens a burst.
- R4: The DIP-4 code works as follows. A 16-bit accumulator A is cleared by every control word. Each data word w updates it as A = rotl1(A) ^ w, where rotl1 rotates left by one so that the old bit 15 moves into bit 0. For a control word with upper bits c, let H = rotl1(A) ^ {c, 4'b1111}. Then DIP bit i is the inverse of the XOR of H[i], H[i+4], H[i+8] and H[i+12], for i = 0..3.
- R5: With the FIFO empty and no training running, the block sends an idle control word {12'h000, DIP-4} with `tx_ctl` 1. An idle word closes any open burst.
- R6: One training pattern is ten words of 16'h0FFF with `tx_ctl` 1, followed by ten words of 16'hF000 with `tx_ctl` 0. Training words do not enter the DIP-4 accumulator. The FIFO is not popped while training runs.
- R7: While `link_stat` is 2'b11 (disabled), patterns follow one another with no gap. A pattern that has started always completes all twenty words. A new pattern starts only if the status still reads disabled, or repetitions remain, on the last word.
- R8: With `cfg_period` P != 0 and `cfg_reps` N != 0, a training run of N back-to-back patterns starts once P non-training beats have been sent since reset or since the previous run ended. With an empty FIFO this gives exactly P idle words between runs.
- R9: Training never starts while a burst is open, that is, between a payload control word and the next control word of any kind. A run that fell due during a burst begins on the beat after the control word that closes it.
- R10: `cfg_period` = 0 or `cfg_reps` = 0 disables periodic training.
- R11: A `link_stat` value other than 2'b11 allows normal data flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_stat | input | 2 | Far-end status; 2'b11 means disabled |
| cfg_period | input | 16 | Non-training beats between periodic training runs (0 = off) |
| cfg_reps | input | 8 | Patterns per periodic run (0 = off) |
| fifo_valid | input | 1 | FIFO head entry present |
| fifo_is_ctl | input | 1 | Head entry is a control request |
| fifo_word | input | 16 | Head entry word |
| fifo_rd | output | 1 | Pop the head entry this cycle |
| tx_data | output | 16 | Transmit word |
| tx_ctl | output | 1 | Transmit word is a control word |

## Verification
Two functions can fall on the same beat: a periodic training run falling due, and an open burst that still has words to send. The bench sets a short interval so that it expires partway through a burst. It then checks that every data word and the closing control word still come out in order with the correct DIP-4, and that the first 16'h0FFF appears on the very next beat. A second case lets the FIFO drain in the middle of a burst. There, the idle word must close the burst, and training must follow it at once.

// File: rtl/spi4tx_pkg.sv
package spi4tx_pkg;

  localparam int WORD_W = 16;
  localparam int DIP_W  = 4;
  localparam int HEAD_W = WORD_W - DIP_W;

  localparam logic [WORD_W-1:0] TRAIN_CTL_WORD = 16'h0FFF;
  localparam logic [WORD_W-1:0] TRAIN_DAT_WORD = 16'hF000;
  localparam logic [HEAD_W-1:0] IDLE_HEAD      = 12'h000;
  localparam logic [1:0]        LINK_DISABLED  = 2'b11;
  localparam int                PAYLOAD_BIT    = WORD_W - 1;

  typedef enum logic [1:0] {
    SRC_TRAIN = 2'd0,
    SRC_FIFO  = 2'd1,
    SRC_IDLE  = 2'd2
  } src_e;

  // rotate left by one: bit 15 wraps to bit 0
  function automatic logic [WORD_W-1:0] rotl1(input logic [WORD_W-1:0] v);
    return {v[WORD_W-2:0], v[WORD_W-1]};
  endfunction

  // fold one data word into the running diagonal accumulator
  function automatic logic [WORD_W-1:0] dip_absorb(input logic [WORD_W-1:0] acc,
                                                   input logic [WORD_W-1:0] w);
    return rotl1(acc) ^ w;
  endfunction

  // close the span with a control word whose DIP field is preset to all ones
  function automatic logic [DIP_W-1:0] dip_close(input logic [WORD_W-1:0] acc,
                                                 input logic [HEAD_W-1:0] head);
    logic [WORD_W-1:0] h;
    logic [DIP_W-1:0]  d;
    h = rotl1(acc) ^ {head, {DIP_W{1'b1}}};
    for (int i = 0; i < DIP_W; i++) begin
      logic x;
      x = 1'b0;
      for (int k = 0; k < WORD_W / DIP_W; k++) x = x ^ h[i + DIP_W*k];
      d[i] = ~x;
    end
    return d;
  endfunction

endpackage

// File: rtl/tx_train_timer.sv
module tx_train_timer #(
  parameter int PERIOD_W = 16,
  parameter int REPS_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [REPS_W-1:0]   cfg_reps,
  input  logic                train_active,
  output logic                due
);

  localparam logic [PERIOD_W-1:0] CNT_MAX = '1;

  logic [PERIOD_W-1:0] beat_cnt;
  logic                sched_on;

  assign sched_on = (cfg_period != '0) && (cfg_reps != '0);
  assign due      = sched_on && (beat_cnt >= cfg_period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                beat_cnt <= '0;
    else if (train_active)     beat_cnt <= '0;
    else if (beat_cnt != CNT_MAX) beat_cnt <= beat_cnt + 1'b1;
  end

  // R10
  period_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_period == '0) || (cfg_reps == '0)) |-> !due);

endmodule

// File: rtl/tx_train_seq.sv
module tx_train_seq #(
  parameter int HALF_LEN = 10,
  parameter int REPS_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_dis,
  input  logic              due,
  input  logic              burst_open,
  input  logic [REPS_W-1:0] cfg_reps,
  output logic              seq_active,
  output logic [15:0]       seq_word,
  output logic              seq_ctl
);
  import spi4tx_pkg::*;

  localparam int PAT_LEN = 2 * HALF_LEN;
  localparam int IDX_W   = $clog2(PAT_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_HALF = IDX_W'(HALF_LEN);
  localparam logic [REPS_W-1:0] ONE_REP = REPS_W'(1);

  logic              running;
  logic [IDX_W-1:0]  idx_q;
  logic [REPS_W-1:0] reps_q;

  logic              want, seq_start, pat_end, more;
  logic [IDX_W-1:0]  idx_cur;
  logic [REPS_W-1:0] reps_cur, reps_init;

  assign want       = link_dis | due;
  assign seq_start  = !running && want && !burst_open;
  assign seq_active = running | seq_start;

  assign reps_init  = (cfg_reps == '0) ? ONE_REP : cfg_reps;
  assign idx_cur    = running ? idx_q  : '0;
  assign reps_cur   = running ? reps_q : reps_init;

  assign seq_ctl    = idx_cur < IDX_HALF;
  assign seq_word   = seq_ctl ? TRAIN_CTL_WORD : TRAIN_DAT_WORD;

  assign pat_end    = seq_active && (idx_cur == IDX_LAST);
  assign more       = (reps_cur > ONE_REP) || link_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx_q   <= '0;
      reps_q  <= '0;
    end else if (!seq_active) begin
      running <= 1'b0;
      idx_q   <= '0;
    end else if (pat_end) begin
      idx_q <= '0;
      if (more) begin
        running <= 1'b1;
        reps_q  <= (reps_cur > ONE_REP) ? reps_cur - 1'b1 : reps_cur;
      end else begin
        running <= 1'b0;
      end
    end else begin
      running <= 1'b1;
      idx_q   <= idx_cur + 1'b1;
      reps_q  <= reps_cur;
    end
  end

  // R7
  keep_training_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && link_dis) |=> seq_active);

  // R6
  pattern_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && !pat_end) |=> seq_active);

endmodule

// File: rtl/tx_dip_gen.sv
module tx_dip_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_beat,
  input  logic        ctl_beat,
  input  logic [15:0] data_word,
  input  logic [11:0] ctl_head,
  output logic [15:0] sealed_word
);
  import spi4tx_pkg::*;

  logic [WORD_W-1:0] acc_q;

  assign sealed_word = {ctl_head, dip_close(acc_q, ctl_head)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (data_beat) acc_q <= dip_absorb(acc_q, data_word);
    else if (ctl_beat)  acc_q <= '0;
  end

  // R4
  beat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_beat && ctl_beat));

endmodule

// File: rtl/spi4_tx_framer.sv
module spi4_tx_framer #(
  parameter int PERIOD_W = 16,
  parameter int REPS_W   = 8,
  parameter int HALF_LEN = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          link_stat,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [REPS_W-1:0]   cfg_reps,
  input  logic                fifo_valid,
  input  logic                fifo_is_ctl,
  input  logic [15:0]         fifo_word,
  output logic                fifo_rd,
  output logic [15:0]         tx_data,
  output logic                tx_ctl
);
  import spi4tx_pkg::*;

  logic        link_dis, due, burst_open, burst_nxt;
  logic        seq_active, seq_ctl;
  logic [15:0] seq_word, sealed_word;
  logic        data_beat, ctl_beat;
  logic [11:0] ctl_head;
  logic [15:0] nxt_data;
  logic        nxt_ctl;
  src_e        src;

  assign link_dis = (link_stat == LINK_DISABLED);

  tx_train_timer #(.PERIOD_W(PERIOD_W), .REPS_W(REPS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_reps(cfg_reps),
    .train_active(seq_active), .due(due));

  tx_train_seq #(.HALF_LEN(HALF_LEN), .REPS_W(REPS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .link_dis(link_dis), .due(due),
    .burst_open(burst_open), .cfg_reps(cfg_reps), .seq_active(seq_active),
    .seq_word(seq_word), .seq_ctl(seq_ctl));

  always_comb begin
    if (seq_active)      src = SRC_TRAIN;
    else if (fifo_valid) src = SRC_FIFO;
    else                 src = SRC_IDLE;
  end

  assign fifo_rd   = (src == SRC_FIFO);
  assign data_beat = fifo_rd && !fifo_is_ctl;
  assign ctl_beat  = (fifo_rd && fifo_is_ctl) || (src == SRC_IDLE) || seq_active;
  assign ctl_head  = (src == SRC_FIFO) ? fifo_word[15:4] : IDLE_HEAD;

  tx_dip_gen u_dip (
    .clk(clk), .rst_n(rst_n), .data_beat(data_beat), .ctl_beat(ctl_beat),
    .data_word(fifo_word), .ctl_head(ctl_head), .sealed_word(sealed_word));

  always_comb begin
    nxt_data  = sealed_word;
    nxt_ctl   = 1'b1;
    burst_nxt = burst_open;
    unique case (src)
      SRC_TRAIN: begin
        nxt_data = seq_word;
        nxt_ctl  = seq_ctl;
      end
      SRC_FIFO: begin
        if (fifo_is_ctl) begin
          burst_nxt = fifo_word[PAYLOAD_BIT];
        end else begin
          nxt_data = fifo_word;
          nxt_ctl  = 1'b0;
        end
      end
      default: burst_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data    <= {IDLE_HEAD, 4'h0};
      tx_ctl     <= 1'b1;
      burst_open <= 1'b0;
    end else begin
      tx_data    <= nxt_data;
      tx_ctl     <= nxt_ctl;
      burst_open <= burst_nxt;
    end
  end

  // R2
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !fifo_is_ctl) |=> (!tx_ctl && tx_data == $past(fifo_word)));

  // R3
  ctl_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && fifo_is_ctl) |=> (tx_ctl && tx_data[15:4] == $past(fifo_word[15:4])));

  // R5
  idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_valid && !seq_active) |=> (tx_ctl && tx_data[15:4] == IDLE_HEAD));

  // R6
  no_pop_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |-> !fifo_rd);

  // R9
  burst_train_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_open |-> !seq_active);

endmodule

// File: tb/sim_spi4_tx_framer.sv
`timescale 1ns/1ps
module sim_spi4_tx_framer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  link_stat;
  logic [15:0] cfg_period;
  logic [7:0]  cfg_reps;
  logic        fifo_valid, fifo_is_ctl;
  logic [15:0] fifo_word;
  logic        fifo_rd;
  logic [15:0] tx_data;
  logic        tx_ctl;

  int checks = 0;
  int errors = 0;
  logic        rd_seen;
  logic [15:0] macc;

  always #10 clk = ~clk;

  spi4_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .link_stat(link_stat), .cfg_period(cfg_period),
    .cfg_reps(cfg_reps), .fifo_valid(fifo_valid), .fifo_is_ctl(fifo_is_ctl),
    .fifo_word(fifo_word), .fifo_rd(fifo_rd), .tx_data(tx_data), .tx_ctl(tx_ctl));

  // {is_ctl, word}
  localparam logic [16:0] TBL [12] = '{
    17'h19123, 17'h0A5A5, 17'h01234, 17'h0FFFF,
    17'h1A056, 17'h00001, 17'h08000, 17'h1D7A0,
    17'h00F0F, 17'h16000, 17'h18009, 17'h0BEEF
  };

  function automatic logic [3:0] ref_dip(input logic [15:0] acc, input logic [15:0] tpl);
    logic [15:0] h;
    logic [3:0]  r;
    h = {acc[14:0], acc[15]} ^ {tpl[15:4], 4'b1111};
    for (int b = 0; b < 4; b++) begin
      int ones;
      ones = 0;
      for (int k = 0; k < 4; k++) ones += int'(h[b + 4*k]);
      r[b] = (ones % 2 == 0);
    end
    return r;
  endfunction

  function automatic logic [15:0] ref_seal(input logic [15:0] acc, input logic [15:0] tpl);
    return {tpl[15:4], ref_dip(acc, tpl)};
  endfunction

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input string req, input logic [15:0] gd, input logic gc,
                       input logic [15:0] ed, input logic ec);
    checks++;
    if (gd !== ed || gc !== ec) begin
      errors++;
      $display("FAIL %s: got %h/%b expected %h/%b", req, gd, gc, ed, ec);
    end
  endtask

  task automatic beat(input logic v, input logic isc, input logic [15:0] w,
                      input logic [15:0] ed, input logic ec, input string req);
    fifo_valid = v; fifo_is_ctl = isc; fifo_word = w;
    @(negedge clk);
    rd_seen = fifo_rd;
    @(posedge clk);
    #1;
    check(req, tx_data, tx_ctl, ed, ec);
  endtask

  task automatic do_reset(input logic [15:0] p, input logic [7:0] n);
    rst_n = 1'b0; fifo_valid = 1'b0; fifo_is_ctl = 1'b0; fifo_word = '0;
    link_stat = 2'b00; cfg_period = p; cfg_reps = n; macc = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset", tx_data, tx_ctl, 16'h0000, 1'b1);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  function automatic logic [16:0] train_at(input int j);
    return ((j % 20) < 10) ? {1'b1, 16'h0FFF} : {1'b0, 16'hF000};
  endfunction

  task automatic train_beat(input logic v, input logic isc, input logic [15:0] w,
                            input int j, input string req);
    logic [16:0] t;
    t = train_at(j);
    beat(v, isc, w, t[15:0], t[16], req);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    do_reset(16'd0, 8'd0);

    // table walk: link status not disabled, data flows (R2 R3 R4 R11)
    link_stat = 2'b01;
    for (int e = 0; e < 12; e++) begin
      logic [15:0] ew;
      logic        ec;
      if (e == 6) link_stat = 2'b10;
      if (TBL[e][16]) begin
        ew = ref_seal(macc, TBL[e][15:0]); ec = 1'b1; macc = '0;
      end else begin
        ew = TBL[e][15:0]; ec = 1'b0; macc = {macc[14:0], macc[15]} ^ TBL[e][15:0];
      end
      beat(1'b1, TBL[e][16], TBL[e][15:0], ew, ec, "R2 R3 R4 R11 table");
      checks++;
      if (rd_seen !== 1'b1) begin
        errors++; $display("FAIL R11 pop: got %b expected 1", rd_seen);
      end
    end

    // R5 idle words close the span
    beat(1'b0, 1'b0, 16'h0, ref_seal(macc, 16'h0000), 1'b1, "R5 idle after data");
    macc = '0;
    beat(1'b0, 1'b0, 16'h0, 16'h0000, 1'b1, "R5 idle empty span");

    // R7 continuous training while disabled, R6 pattern and no pop
    link_stat = 2'b11;
    for (int j = 0; j < 40; j++) begin
      if (j == 25) link_stat = 2'b00;
      train_beat(1'b1, 1'b1, 16'h6000, j, "R6 R7 training");
      checks++;
      if (rd_seen !== 1'b0) begin
        errors++; $display("FAIL R6 pop in training: got %b expected 0", rd_seen);
      end
    end
    beat(1'b1, 1'b1, 16'h6000, ref_seal(16'h0000, 16'h6000), 1'b1, "R6 DIP after training");
    beat(1'b0, 1'b0, 16'h0, 16'h0000, 1'b1, "R7 stops after status clears");

    // R8 periodic training: P=5, N=2
    do_reset(16'd5, 8'd2);
    for (int j = 0; j < 51; j++) begin
      if (j < 5 || (j >= 45 && j < 50))
        beat(1'b0, 1'b0, 16'h0, 16'h0000, 1'b1, "R8 idle gap");
      else
        train_beat(1'b0, 1'b0, 16'h0, j - 5, "R8 periodic run");
    end

    // R9 due during burst: deferred to the beat after the closing control word
    do_reset(16'd4, 8'd1);
    macc = '0;
    beat(1'b1, 1'b1, 16'h9123, ref_seal(macc, 16'h9123), 1'b1, "R9 open burst");
    for (int j = 1; j < 7; j++) begin
      logic [15:0] w;
      w = 16'h1111 * j[15:0];
      beat(1'b1, 1'b0, w, w, 1'b0, "R9 burst data kept");
      macc = {macc[14:0], macc[15]} ^ w;
    end
    beat(1'b1, 1'b1, 16'h4000, ref_seal(macc, 16'h4000), 1'b1, "R9 closing control");
    for (int j = 0; j < 20; j++)
      train_beat(1'b0, 1'b0, 16'h0, j, "R9 deferred training");
    beat(1'b0, 1'b0, 16'h0, 16'h0000, 1'b1, "R9 idle after run");

    // R9 R5 idle closes a drained burst, training follows at once
    do_reset(16'd1, 8'd1);
    beat(1'b1, 1'b1, 16'h9123, ref_seal(16'h0, 16'h9123), 1'b1, "R9 open");
    beat(1'b1, 1'b0, 16'h5555, 16'h5555, 1'b0, "R9 data while due");
    beat(1'b0, 1'b0, 16'h0, ref_seal(16'h5555, 16'h0000), 1'b1, "R5 idle closes burst");
    train_beat(1'b0, 1'b0, 16'h0, 0, "R9 training after idle");

    // R10 periodic training disabled
    do_reset(16'd0, 8'd3);
    for (int j = 0; j < 30; j++)
      beat(1'b0, 1'b0, 16'h0, 16'h0000, 1'b1, "R10 period zero");
    do_reset(16'd3, 8'd0);
    for (int j = 0; j < 30; j++)
      beat(1'b0, 1'b0, 16'h0, 16'h0000, 1'b1, "R10 reps zero");

    report();
  end

endmodule